// File: doc/BRIEF.md
# Receive Descriptor Poll Controller

This block keeps the run state of one receive DMA channel that walks a list of descriptors held in memory. Software loads the start address of the descriptor list through a small register port, then issues a start command. The channel then asks a descriptor fetch unit for the descriptor at its current pointer. Each descriptor that comes back marked as owned by the DMA moves the pointer forward by one fixed descriptor size. The first descriptor that is still owned by software parks the channel in a suspended state.

A suspended channel wakes only when software writes any value to the poll register. That write causes exactly one new ownership check. If the descriptor is now available, the channel keeps running. If it is still held by software, the channel drops straight back to suspended and waits for the next poll. A stop command returns the channel to stopped from any state. The list base address can only be changed while the channel is stopped.

The register port decodes word offsets from a byte address. Offset 0x0 is the control register: bit 0 is start and bit 1 is stop. Offset 0x4 is the poll register. Offset 0x8 is the list base address. Writes take effect at the clock edge on which `reg_wr` is sampled high. Read data is registered and appears one cycle after the address is presented.

Top module: `rx_desc_poll_ctrl`

## Requirements
- R1: After a synchronous reset the state output reads STOPPED (encoding 0), the current pointer is 0, `desc_req` is low and the base register reads 0.
- R2: A write to the base register (offset 0x8) while STOPPED stores the write data with bits 1:0 forced to zero, and a read of offset 0x8 returns that value.
- R3: A write to the base register while RUNNING (encoding 1) or SUSPENDED (encoding 2) is ignored, so the read value stays unchanged.
- R4: A control write with bit 0 set and bit 1 clear, made while STOPPED, loads the current pointer from the base register and gives RUNNING on the next cycle. A start in any other state has no effect.
- R5: A control write with bit 1 set gives STOPPED on the next cycle from any state. This takes priority over a start bit in the same write and over a descriptor result in the same cycle. The pointer holds its value.
- R6: In RUNNING, a descriptor result (`desc_valid`) with `desc_owned` high advances the pointer by DESC_BYTES and stays in RUNNING.
- R7: In RUNNING, a descriptor result with `desc_owned` low gives SUSPENDED and leaves the pointer unchanged.
- R8: A write of any value to the poll register (offset 0x4) while SUSPENDED gives RUNNING, which triggers one new descriptor check. A poll write while STOPPED or RUNNING has no effect.
- R9: The poll register and the control register always read as zero.
- R10: `desc_req` is high exactly while the state is RUNNING. A descriptor result outside RUNNING changes neither the state nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address (word offsets 0x0, 0x4, 0x8) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |
| desc_req | output | 1 | Request to the fetch unit for the descriptor at `cur_desc_addr` |
| desc_valid | input | 1 | Fetch unit returns an ownership result this cycle |
| desc_owned | input | 1 | The returned descriptor is owned by the DMA |
| cur_desc_addr | output | ADDR_W | Current descriptor pointer |
| chan_state | output | 2 | Channel state: 0 stopped, 1 running, 2 suspended |

## Verification
The bench first runs directed sequences. These separate an owned result (the pointer steps and the channel keeps running) from an unowned one (the pointer holds and the channel suspends). They also cover a poll with all-zero and with all-one data, which shows that the data value does not matter. Polls and base writes are issued in each of the three states, so the state-dependent gating shows up in both the accepted and the ignored cases. Same-cycle collisions cover stop with start and stop with a descriptor result, which shows the stop priority. A seeded random mix of base writes, commands with random data, polls and ownership results then runs against a bench model and exposes wrong ordering of these events.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    ST_STOPPED   = 2'd0,
    ST_RUNNING   = 2'd1,
    ST_SUSPENDED = 2'd2
  } chan_state_e;

  // word index of each register in the map
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_POLL = 1;
  localparam int unsigned REG_BASE = 2;

  // control register bit positions
  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;

endpackage

// File: rtl/dpc_regs.sv
module dpc_regs
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  chan_state_e       state_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              poll_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned IDX_W = REG_AW - 2;

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] rdata_n;
  logic              unused_low_addr;

  assign idx             = reg_addr[REG_AW-1:2];
  assign unused_low_addr = ^reg_addr[1:0];

  // command pulses act on the same edge the write is sampled
  assign start_o = reg_wr && (idx == IDX_W'(REG_CTRL)) && reg_wdata[CTRL_START_BIT];
  assign stop_o  = reg_wr && (idx == IDX_W'(REG_CTRL)) && reg_wdata[CTRL_STOP_BIT];
  assign poll_o  = reg_wr && (idx == IDX_W'(REG_POLL));

  // base register is locked unless the channel is stopped; word aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (reg_wr && (idx == IDX_W'(REG_BASE)) && (state_i == ST_STOPPED)) begin
      base_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
    end
  end

  always_comb begin
    rdata_n = '0;
    if (idx == IDX_W'(REG_BASE)) begin
      rdata_n[ADDR_W-1:0] = base_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= rdata_n;
    end
  end

  assign base_o = base_q;

endmodule

// File: rtl/dpc_fsm.sv
module dpc_fsm
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              poll_i,
  input  logic              desc_valid_i,
  input  logic              desc_owned_i,
  input  logic [ADDR_W-1:0] base_i,
  output chan_state_e       state_o,
  output logic [ADDR_W-1:0] cur_o,
  output logic              desc_req_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  chan_state_e       st_q, st_n;
  logic [ADDR_W-1:0] cur_q, cur_n;
  logic              req_q;

  always_comb begin
    st_n  = st_q;
    cur_n = cur_q;
    if (stop_i) begin
      st_n = ST_STOPPED;
    end else begin
      case (st_q)
        ST_STOPPED: begin
          if (start_i) begin
            st_n  = ST_RUNNING;
            cur_n = base_i;
          end
        end
        ST_RUNNING: begin
          if (desc_valid_i) begin
            if (desc_owned_i) cur_n = cur_q + STEP;
            else              st_n  = ST_SUSPENDED;
          end
        end
        ST_SUSPENDED: begin
          // a poll re-enters running, which re-checks the same descriptor
          if (poll_i) st_n = ST_RUNNING;
        end
        default: st_n = ST_STOPPED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_STOPPED;
      cur_q <= '0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cur_q <= cur_n;
      req_q <= (st_n == ST_RUNNING);
    end
  end

  assign state_o    = st_q;
  assign cur_o      = cur_q;
  assign desc_req_o = req_q;

endmodule

// File: rtl/rx_desc_poll_ctrl.sv
module rx_desc_poll_ctrl
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned REG_AW     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              desc_req,
  input  logic              desc_valid,
  input  logic              desc_owned,
  output logic [ADDR_W-1:0] cur_desc_addr,
  output logic [1:0]        chan_state
);

  chan_state_e       state;
  logic              start_cmd, stop_cmd, poll_cmd;
  logic [ADDR_W-1:0] base_addr;

  dpc_regs #(
    .ADDR_W (ADDR_W),
    .REG_AW (REG_AW),
    .DATA_W (DATA_W)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .state_i   (state),
    .start_o   (start_cmd),
    .stop_o    (stop_cmd),
    .poll_o    (poll_cmd),
    .base_o    (base_addr),
    .rdata_o   (reg_rdata)
  );

  dpc_fsm #(
    .ADDR_W     (ADDR_W),
    .DESC_BYTES (DESC_BYTES)
  ) i_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_cmd),
    .stop_i       (stop_cmd),
    .poll_i       (poll_cmd),
    .desc_valid_i (desc_valid),
    .desc_owned_i (desc_owned),
    .base_i       (base_addr),
    .state_o      (state),
    .cur_o        (cur_desc_addr),
    .desc_req_o   (desc_req)
  );

  assign chan_state = state;

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned REG_AW     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              desc_req,
  input logic              desc_valid,
  input logic              desc_owned,
  input logic [ADDR_W-1:0] cur_desc_addr,
  input logic [1:0]        chan_state,
  input logic [ADDR_W-1:0] base_q
);

  logic ctrl_wr, poll_wr, base_wr, start_w, stop_w;
  logic unused_bits;

  assign ctrl_wr     = reg_wr && (reg_addr[REG_AW-1:2] == '0);
  assign poll_wr     = reg_wr && (reg_addr[REG_AW-1:2] == (REG_AW-2)'(1));
  assign base_wr     = reg_wr && (reg_addr[REG_AW-1:2] == (REG_AW-2)'(2));
  assign start_w     = ctrl_wr && reg_wdata[0];
  assign stop_w      = ctrl_wr && reg_wdata[1];
  assign unused_bits = ^{reg_addr[1:0], reg_wdata};

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (chan_state == 2'd0 && !desc_req && cur_desc_addr == '0));

  assert_aligned_base_R2: assert property (@(posedge clk) disable iff (rst)
    base_q[1:0] == 2'b00);

  assert_base_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (base_wr && chan_state != 2'd0) |=> $stable(base_q));

  assert_start_loads_R4: assert property (@(posedge clk) disable iff (rst)
    (chan_state == 2'd0 && start_w && !stop_w) |=>
      (chan_state == 2'd1 && cur_desc_addr == $past(base_q)));

  assert_stop_wins_R5: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> (chan_state == 2'd0 && $stable(cur_desc_addr)));

  assert_owned_step_R6: assert property (@(posedge clk) disable iff (rst)
    (chan_state == 2'd1 && desc_valid && desc_owned && !stop_w) |=>
      (chan_state == 2'd1 && cur_desc_addr == $past(cur_desc_addr) + ADDR_W'(DESC_BYTES)));

  assert_unowned_suspend_R7: assert property (@(posedge clk) disable iff (rst)
    (chan_state == 2'd1 && desc_valid && !desc_owned && !stop_w) |=>
      (chan_state == 2'd2 && $stable(cur_desc_addr)));

  assert_poll_resume_R8: assert property (@(posedge clk) disable iff (rst)
    (chan_state == 2'd2 && poll_wr && !stop_w) |=> chan_state == 2'd1);

  assert_poll_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (chan_state == 2'd0 && poll_wr && !start_w) |=> chan_state == 2'd0);

  assert_req_tracks_R10: assert property (@(posedge clk) disable iff (rst)
    desc_req == (chan_state == 2'd1));

endmodule

bind rx_desc_poll_ctrl dpc_checker #(
  .ADDR_W     (ADDR_W),
  .REG_AW     (REG_AW),
  .DATA_W     (DATA_W),
  .DESC_BYTES (DESC_BYTES)
) i_dpc_checker (
  .clk           (clk),
  .rst           (rst),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .desc_req      (desc_req),
  .desc_valid    (desc_valid),
  .desc_owned    (desc_owned),
  .cur_desc_addr (cur_desc_addr),
  .chan_state    (chan_state),
  .base_q        (base_addr)
);

// File: tb/test_rx_desc_poll_ctrl.sv
`timescale 1ns/1ps
module test_rx_desc_poll_ctrl;

  localparam int unsigned DB = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        desc_req;
  logic        desc_valid;
  logic        desc_owned;
  logic [31:0] cur_desc_addr;
  logic [1:0]  chan_state;

  always #2.5 clk = ~clk;

  rx_desc_poll_ctrl #(
    .ADDR_W(32), .REG_AW(4), .DATA_W(32), .DESC_BYTES(DB)
  ) i_rx_desc_poll_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_req(desc_req),
    .desc_valid(desc_valid), .desc_owned(desc_owned),
    .cur_desc_addr(cur_desc_addr), .chan_state(chan_state)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [1:0]  e_st;
  logic [31:0] e_cur, e_base;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model of the requirements
  task automatic mdl_write(int idx, logic [31:0] d);
    case (idx)
      0: if (d[1]) e_st = 2'd0;
         else if (d[0] && e_st == 2'd0) begin e_st = 2'd1; e_cur = e_base; end
      1: if (e_st == 2'd2) e_st = 2'd1;
      2: if (e_st == 2'd0) e_base = {d[31:2], 2'b00};
      default: ;
    endcase
  endtask

  task automatic mdl_desc(bit own);
    if (e_st == 2'd1) begin
      if (own) e_cur = e_cur + DB;
      else     e_st  = 2'd2;
    end
  endtask

  task automatic do_wr(int idx, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(idx << 2); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    mdl_write(idx, d);
  endtask

  task automatic do_desc(bit own);
    @(negedge clk);
    desc_valid = 1'b1; desc_owned = own;
    @(negedge clk);
    desc_valid = 1'b0;
    mdl_desc(own);
  endtask

  task automatic do_rd(int idx, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 4'(idx << 2);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic check_all(string tag);
    chk({tag, " state"}, 32'(chan_state), 32'(e_st));
    chk({tag, " pointer"}, cur_desc_addr, e_cur);
    chk({"R10 ", tag, " desc_req"}, 32'(desc_req), 32'(e_st == 2'd1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    desc_valid = 1'b0; desc_owned = 1'b0;
    e_st = 2'd0; e_cur = '0; e_base = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_all("R1 reset");
    do_rd(2, v); chk("R1 base after reset", v, 32'h0);

    // R2 aligned base write while stopped
    do_wr(2, 32'h1000_0003);
    do_rd(2, v); chk("R2 base readback", v, 32'h1000_0000);

    // R8 poll while stopped has no effect
    do_wr(1, 32'h0000_0001); check_all("R8 poll in stopped");

    // R4 start loads pointer
    do_wr(0, 32'h1); check_all("R4 start");
    chk("R4 pointer equals base", cur_desc_addr, 32'h1000_0000);

    // R3 base locked while running; R4 start again ignored; R8 poll ignored
    do_wr(2, 32'hDEAD_BEEC);
    do_rd(2, v); chk("R3 base locked running", v, 32'h1000_0000);
    do_wr(0, 32'h1); check_all("R4 start while running");
    do_wr(1, 32'h5);  check_all("R8 poll while running");

    // R6 owned descriptors advance
    do_desc(1'b1); do_desc(1'b1); check_all("R6 owned x2");
    chk("R6 pointer two steps", cur_desc_addr, 32'h1000_0020);

    // R7 unowned suspends
    do_desc(1'b0); check_all("R7 unowned");
    chk("R7 state suspended", 32'(chan_state), 32'd2);

    // R10 result ignored outside running; R3 locked when suspended
    do_desc(1'b1); check_all("R10 result in suspended");
    do_wr(2, 32'h2222_2220);
    do_rd(2, v); chk("R3 base locked suspended", v, 32'h1000_0000);

    // R8 poll with zero data, still unowned, back to suspended
    do_wr(1, 32'h0); check_all("R8 poll zero data");
    do_desc(1'b0); check_all("R8 recheck unowned");
    do_wr(1, 32'hFFFF_FFFF); check_all("R8 poll ones data");
    do_desc(1'b1); check_all("R8 recheck owned");

    // R9 poll and control read zero
    do_rd(1, v); chk("R9 poll reads zero", v, 32'h0);
    do_rd(0, v); chk("R9 control reads zero", v, 32'h0);

    // R5 stop beats a same-cycle descriptor result
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h2;
    desc_valid = 1'b1; desc_owned = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; desc_valid = 1'b0;
    mdl_write(0, 32'h2);
    check_all("R5 stop with result");

    // R5 stop beats start in the same write
    do_wr(0, 32'h3); check_all("R5 start plus stop");
    chk("R5 state stopped", 32'(chan_state), 32'd0);

    // random phase
    for (int i = 0; i < 500; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: do_wr(2, $urandom());
        2:    do_wr(0, 32'h1);
        3:    do_wr(0, $urandom() | 32'h2);
        4:    do_wr(0, $urandom());
        5, 6: do_desc(1'b1);
        7:    do_desc(1'b0);
        8:    do_wr(1, $urandom());
        default: begin
          do_rd(2, v); chk("R2 R3 random base readback", v, e_base);
        end
      endcase
      check_all("R4 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule